// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder

This block turns a 4-bit binary-coded decimal digit into the seven segment drive signals of a numeric display. Segments are active high and named a through g. A storage register sits in front of the decoder. While the hold input is low, the decoder follows the live digit and the register keeps taking in each new value. While hold is high, the display keeps showing the last digit that was taken in.

Two active-low overrides act on the output side only. Lamp test lights every segment. Blanking turns every segment off. An external pulse stream on the blanking input can therefore dim the display. Lamp test wins over blanking, and blanking wins over the decoded digit. Codes 10 to 15 are not decimal digits, so they show a dark display. Digits 6 and 9 are drawn without tails. The segment outputs are registered, so they change one clock after their inputs change.

Top module: `bcd_seg_latch`

## Requirements
- R1: A synchronous active-high reset clears the stored digit to 0 and turns all segments off. After reset is released, with hold high and both overrides high, the display shows digit 0.
- R2: When lamp test is low, all seven segments are on one clock later, whatever the blanking, hold and digit inputs are.
- R3: When lamp test is high and blanking is low, all segments are off one clock later, whatever the hold and digit inputs are.
- R4: When hold is low, the segments show the live digit one clock later. The digit bits are 8421 weighted, with bit 3 as the most significant. The stored digit is replaced at every such edge.
- R5: When hold is high, the segments show the digit stored at the last clock edge at which hold was low. Changes on the digit input have no effect.
- R6: Codes 10 to 15 give all segments off. This holds both for a live code and for a code held in the register.
- R7: The output is 7 bits, with segment a at bit 6 down to segment g at bit 0. The patterns are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=0011111, 7=1110000, 8=1111111, 9=1110011. Digit 6 has no segment a, and digit 9 has no segment d.
- R8: Blanking and lamp test do not disturb the stored digit. The held digit shows again once both overrides return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| digitIn | input | 4 | BCD digit, 8421 weighted, bit 3 most significant |
| holdEn | input | 1 | High: hold the stored digit. Low: follow digitIn and store it |
| blankN | input | 1 | Active-low blanking of all segments |
| testN | input | 1 | Active-low lamp test, lights all segments |
| segOut | output | 7 | Segment drive, a at bit 6 down to g at bit 0, active high |

## Verification
All sixteen input codes are driven with hold low. This separates the ten decimal patterns from one another, including the tail-less 6 and 9, and separates them from the six illegal codes that must go dark. Digits are then stored and the input is moved while hold is high, which shows whether the register really holds. One of the stored codes is an illegal one, which shows that a held illegal code also stays dark. The override patterns drive blanking and lamp test alone and together, with hold both high and low. The live input keeps changing under them, so the tests show the priority of lamp test over blanking, and that the stored digit comes back unchanged once both overrides are released.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCode;  // take the live digit into the store
    logic useLive;   // decode the live digit instead of the store
    logic forceOn;   // lamp test
    logic forceOff;  // blanking
  } segStrobe_t;

  // segment a at the top bit down to g at bit 0
  function automatic logic [SEG_W-1:0] digitToSeg(input logic [CODE_W-1:0] code);
    logic [SEG_W-1:0] pat;
    case (code)
      4'd0:    pat = 7'b1111110;
      4'd1:    pat = 7'b0110000;
      4'd2:    pat = 7'b1101101;
      4'd3:    pat = 7'b1111001;
      4'd4:    pat = 7'b0110011;
      4'd5:    pat = 7'b1011011;
      4'd6:    pat = 7'b0011111;
      4'd7:    pat = 7'b1110000;
      4'd8:    pat = 7'b1111111;
      4'd9:    pat = 7'b1110011;
      default: pat = '0;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
(
  input  logic       holdEn,
  input  logic       blankN,
  input  logic       testN,
  output segStrobe_t strobes
);
  always_comb begin
    strobes.loadCode = ~holdEn;
    strobes.useLive  = ~holdEn;
    strobes.forceOn  = ~testN;
    strobes.forceOff = testN & ~blankN;
  end
endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_pkg::*;
#(
  parameter int CODE_BITS = CODE_W,
  parameter int SEG_BITS  = SEG_W,
  parameter int MAX_DIGIT = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CODE_BITS-1:0] digitIn,
  input  segStrobe_t           strobes,
  output logic [SEG_BITS-1:0]  segOut
);
  localparam logic [SEG_BITS-1:0]  ALL_ON  = {SEG_BITS{1'b1}};
  localparam logic [SEG_BITS-1:0]  ALL_OFF = '0;
  localparam logic [CODE_BITS-1:0] TOP_OK  = CODE_BITS'(MAX_DIGIT);

  logic [CODE_BITS-1:0] storedCode;
  logic [CODE_BITS-1:0] decodeSrc;
  logic [SEG_BITS-1:0]  decoded;
  logic [SEG_BITS-1:0]  segNext;

  always_ff @(posedge clk) begin
    if (rst)                   storedCode <= '0;
    else if (strobes.loadCode) storedCode <= digitIn;
  end

  always_comb begin
    decodeSrc = strobes.useLive ? digitIn : storedCode;
    decoded   = (decodeSrc > TOP_OK) ? ALL_OFF : digitToSeg(decodeSrc);
    if (strobes.forceOn)       segNext = ALL_ON;
    else if (strobes.forceOff) segNext = ALL_OFF;
    else                       segNext = decoded;
  end

  always_ff @(posedge clk) begin
    if (rst) segOut <= ALL_OFF;
    else     segOut <= segNext;
  end

  // R2: lamp test lights everything on the next edge
  p_lamp_all_on_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.forceOn |=> (segOut == ALL_ON));

  // R3: blanking darkens everything when lamp test is inactive
  p_blank_all_off_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.forceOff && !strobes.forceOn) |=> (segOut == ALL_OFF));

  // R5 and R8: the store keeps its digit whenever no load is asked for
  p_store_holds_r5: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadCode |=> $stable(storedCode));

  // R6: an illegal source code never lights a segment
  p_illegal_dark_r6: assert property (@(posedge clk) disable iff (rst)
    (!strobes.forceOn && decodeSrc > TOP_OK) |=> (segOut == ALL_OFF));

  // R4: a load takes the live digit
  p_load_takes_live_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.loadCode |=> (storedCode == $past(digitIn)));
endmodule

// File: rtl/bcd_seg_latch.sv
module bcd_seg_latch
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] digitIn,
  input  logic              holdEn,
  input  logic              blankN,
  input  logic              testN,
  output logic [SEG_W-1:0]  segOut
);
  segStrobe_t strobes;

  seg_ctrl u_ctrl (
    .holdEn  (holdEn),
    .blankN  (blankN),
    .testN   (testN),
    .strobes (strobes)
  );

  seg_datapath #(
    .CODE_BITS (CODE_W),
    .SEG_BITS  (SEG_W),
    .MAX_DIGIT (9)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .digitIn (digitIn),
    .strobes (strobes),
    .segOut  (segOut)
  );
endmodule

// File: tb/bcd_seg_latch_bench.sv
module bcd_seg_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digitIn = 4'd0;
  logic       holdEn = 1'b1;
  logic       blankN = 1'b1;
  logic       testN  = 1'b1;
  logic [6:0] segOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  string tagNow = "R1";
  string expTag = "R1";
  logic [6:0] expSeg = '0;
  bit expValid = 1'b0;
  int modelCode = 0;
  int patterns[10] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33, 7'h5B, 7'h1F, 7'h70, 7'h7F, 7'h73};

  bcd_seg_latch u_bcd_seg_latch (
    .clk(clk), .rst(rst), .digitIn(digitIn), .holdEn(holdEn),
    .blankN(blankN), .testN(testN), .segOut(segOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, evaluated at every rising edge
  always @(posedge clk) begin
    int src;
    expTag = tagNow;
    expValid = 1'b1;
    if (rst) begin
      modelCode = 0;
      expSeg = '0;
    end else begin
      src = holdEn ? modelCode : int'(digitIn);
      if (!testN)       expSeg = 7'h7F;
      else if (!blankN) expSeg = 7'h00;
      else if (src > 9) expSeg = 7'h00;
      else              expSeg = 7'(patterns[src]);
      if (!holdEn) modelCode = int'(digitIn);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (expValid) begin
      checks++;
      if (segOut !== expSeg) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", expTag, segOut, expSeg);
      end
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected=end of stimulus", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(input string tag, input logic [3:0] d, input logic h,
                       input logic b, input logic t);
    @(negedge clk);
    tagNow = tag; digitIn = d; holdEn = h; blankN = b; testN = t;
  endtask

  initial begin
    // R1: reset state
    repeat (3) drive("R1", 4'd8, 1'b0, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b0;
    drive("R1", 4'd4, 1'b1, 1'b1, 1'b1);
    drive("R1", 4'd7, 1'b1, 1'b1, 1'b1);
    // R4 R7 R6: every live code
    for (int c = 0; c < 16; c++)
      drive(c > 9 ? "R6" : "R4_R7", 4'(c), 1'b0, 1'b1, 1'b1);
    for (int c = 15; c >= 0; c -= 3)
      drive(c > 9 ? "R6" : "R4", 4'(c), 1'b0, 1'b1, 1'b1);
    // R5: store 5, then move input while holding
    drive("R4", 4'd5, 1'b0, 1'b1, 1'b1);
    for (int c = 0; c < 16; c++)
      drive("R5", 4'(c), 1'b1, 1'b1, 1'b1);
    // R6: held illegal code stays dark
    drive("R6", 4'd12, 1'b0, 1'b1, 1'b1);
    for (int c = 0; c < 10; c++)
      drive("R6", 4'(c), 1'b1, 1'b1, 1'b1);
    // R3 R2 R8: overrides on a held 7
    drive("R4", 4'd7, 1'b0, 1'b1, 1'b1);
    drive("R3", 4'd2, 1'b1, 1'b0, 1'b1);
    drive("R3", 4'd9, 1'b1, 1'b0, 1'b1);
    drive("R2", 4'd1, 1'b1, 1'b0, 1'b0);
    drive("R2", 4'd14, 1'b1, 1'b1, 1'b0);
    drive("R8", 4'd3, 1'b1, 1'b1, 1'b1);
    drive("R8", 4'd3, 1'b1, 1'b1, 1'b1);
    // overrides with hold low, pulsed blanking
    drive("R2", 4'd0, 1'b0, 1'b0, 1'b0);
    drive("R3", 4'd6, 1'b0, 1'b0, 1'b1);
    drive("R4", 4'd6, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++)
      drive(i[0] ? "R3" : "R8", 4'd9, 1'b1, i[0] ? 1'b0 : 1'b1, 1'b1);
    drive("R8", 4'd9, 1'b1, 1'b1, 1'b1);
    drive("R8", 4'd1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule